// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block places a 32x32 two-colour cursor on top of a stream of display pixels. It sits between the pixel source and the display output. Each pixel arrives with its x and y screen coordinates and a valid flag. The block leaves the pixel unchanged, or replaces it with one of two cursor colours that are supplied on input ports. The result leaves one clock later, and the valid flag is delayed by the same clock. Palette lookup, video timing and frame memory belong to other blocks.

The cursor shape is held in two sets of 32 row words. A mask row chooses which columns of that cursor row are opaque. A colour-select row chooses, for each opaque column, between colour A and colour B. Software reaches these rows through a small register window. The same window also holds the cursor position and a miscellaneous word. On reset the cursor is placed far to the right, so nothing is drawn until software moves it.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the cursor position reads as 0xF0000000 (x = 0xF000, y = 0), so the cursor is off screen. The misc word is 0, which reads as 0x02000000. Every mask and colour-select row is 0, and the output valid flag is 0.
- R2: Register offsets are byte offsets, and bits 1:0 of an offset are ignored. The misc word is at 0x818 and the position is at 0x8FC. Mask rows are at 0x900 + 4*r and colour-select rows at 0x980 + 4*r, for r = 0..31. Every one of these reads back what was written, except as stated in R4. Read data appears on `rd_data` one clock after `rd_addr` is presented.
- R3: A write to the position register loads cursor x from bits 31:16 and cursor y from bits 15:0. The position reads back as {x, y}.
- R4: A read of the misc word returns the stored value with bit 25 forced to 1.
- R5: A read from any offset outside the map returns 0. A write to such an offset changes no register.
- R6: The cursor covers screen rows y .. y+31 and columns x .. x+31. It is drawn only when cursor x is less than `active_width`. Pixels outside it pass through unchanged.
- R7: In a cursor row word, bit 31 is the leftmost cursor column. Column c uses bit 31-c.
- R8: At a covered pixel, mask bit 0 passes the pixel through. Mask bit 1 outputs `colour_b` when the colour-select bit is 1, and `colour_a` when it is 0.
- R9: Pixels with x at or beyond `active_width` are never replaced. This clips the cursor at the right edge to min(32, width - x) columns.
- R10: `pix_valid_o` and `pix_data_o` follow the corresponding input pixel by exactly one clock.
- R11: A pixel that enters in the same clock as a register write is composed with the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte offset |
| rd_data | output | 32 | Read data, one clock after rd_addr |
| active_width | input | 16 | Active display width in pixels |
| colour_a | input | PIX_W | Cursor colour for colour-select bit 0 |
| colour_b | input | PIX_W | Cursor colour for colour-select bit 1 |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_x | input | 16 | Input pixel column |
| pix_y | input | 16 | Input pixel row |
| pix_data_i | input | PIX_W | Input pixel value |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_data_o | output | PIX_W | Output pixel value |

## Verification
A register write and a pixel lookup can happen in the same clock. This occurs when software moves the cursor, or rewrites a shape row, while that row is being scanned. The bench provokes it by presenting a pixel on the cursor's top-left corner in the same clock as a position write that moves the cursor away. That pixel must still receive the old cursor colour. The next pixel at the same spot must pass through unchanged. The bench also rewrites a mask row in the same clock as a pixel that uses that row, and judges the result against the old mask.

// File: rtl/curs_pkg.sv
// Package: constants, register offsets and offset decode for the cursor overlay.
// Assumes a square cursor of CURS_DIM rows, one 32-bit word per row.
package curs_pkg;
    localparam int CURS_DIM   = 32;
    localparam int ROW_W      = 32;
    localparam int IDX_W      = $clog2(CURS_DIM);
    localparam int COORD_W    = 16;
    localparam int OFF_W      = 12;
    localparam int DATA_W     = 32;
    localparam int MISC_FORCE = 25;

    localparam logic [OFF_W-1:0]   OFF_MISC = 12'h818;
    localparam logic [OFF_W-1:0]   OFF_POS  = 12'h8FC;
    localparam logic [OFF_W-1:0]   OFF_MASK = 12'h900;
    localparam logic [OFF_W-1:0]   OFF_SEL  = 12'h980;
    localparam logic [COORD_W-1:0] X_PARK   = 16'hF000;

    // Number of low offset bits spanned by one row array (bytes = 4*CURS_DIM).
    localparam int ARR_LSB = IDX_W + 2;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_MISC,
        RS_POS,
        RS_MASK,
        RS_SEL
    } reg_sel_e;

    // Map a byte offset to the register it selects; bits 1:0 are ignored.
    function automatic reg_sel_e decode_off(input logic [OFF_W-1:0] a);
        if (a[OFF_W-1:2] == OFF_MISC[OFF_W-1:2])               return RS_MISC;
        if (a[OFF_W-1:2] == OFF_POS[OFF_W-1:2])                return RS_POS;
        if (a[OFF_W-1:ARR_LSB] == OFF_MASK[OFF_W-1:ARR_LSB])   return RS_MASK;
        if (a[OFF_W-1:ARR_LSB] == OFF_SEL[OFF_W-1:ARR_LSB])    return RS_SEL;
        return RS_NONE;
    endfunction
endpackage

// File: rtl/curs_regs.sv
// Register window of the cursor overlay: position, misc word, and the mask
// and colour-select row arrays. Writes take effect at the clock edge. Read
// data is registered, so it appears one clock after rd_addr. The pixel
// stage reads one row of each array through row_idx.
// Assumes 32-bit word access; offset bits 1:0 are ignored.
module curs_regs
    import curs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [OFF_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [OFF_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic [COORD_W-1:0]   cur_x,
    output logic [COORD_W-1:0]   cur_y,
    input  logic [IDX_W-1:0]     row_idx,
    output logic [ROW_W-1:0]     row_mask,
    output logic [ROW_W-1:0]     row_sel
);
    logic [ROW_W-1:0]  mask_q [CURS_DIM];
    logic [ROW_W-1:0]  sel_q  [CURS_DIM];
    logic [DATA_W-1:0] misc_q;
    logic [DATA_W-1:0] rd_next;
    reg_sel_e          wsel;
    reg_sel_e          rsel;
    logic [IDX_W-1:0]  wrow;
    logic [IDX_W-1:0]  rrow;

    assign wsel = decode_off(wr_addr);
    assign rsel = decode_off(rd_addr);
    assign wrow = wr_addr[ARR_LSB-1:2];
    assign rrow = rd_addr[ARR_LSB-1:2];

    // Position and misc registers; reset parks the cursor off screen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x  <= X_PARK;
            cur_y  <= '0;
            misc_q <= '0;
        end else if (wr_en) begin
            if (wsel == RS_POS) begin
                cur_x <= wr_data[DATA_W-1 -: COORD_W];
                cur_y <= wr_data[COORD_W-1:0];
            end
            if (wsel == RS_MISC) misc_q <= wr_data;
        end
    end

    // One mask row and one colour-select row per cursor line.
    for (genvar r = 0; r < CURS_DIM; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[r] <= '0;
                sel_q[r]  <= '0;
            end else if (wr_en && wrow == IDX_W'(r)) begin
                if (wsel == RS_MASK) mask_q[r] <= wr_data;
                if (wsel == RS_SEL)  sel_q[r]  <= wr_data;
            end
        end
    end

    // Row lookup for the pixel stage.
    assign row_mask = mask_q[row_idx];
    assign row_sel  = sel_q[row_idx];

    // Read multiplexer; misc carries a fixed bit, unmapped offsets give zero.
    always_comb begin
        unique case (rsel)
            RS_MISC: rd_next = misc_q | (DATA_W'(1) << MISC_FORCE);
            RS_POS:  rd_next = {cur_x, cur_y};
            RS_MASK: rd_next = mask_q[rrow];
            RS_SEL:  rd_next = sel_q[rrow];
            default: rd_next = '0;
        endcase
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_next;
    end

    AST_POS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && decode_off(wr_addr) == RS_POS) |=>
        (cur_x == $past(wr_data[31:16]) && cur_y == $past(wr_data[15:0]))); // R3
    AST_MISC_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (decode_off(rd_addr) == RS_MISC) |=> rd_data[MISC_FORCE]); // R4
    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (decode_off(rd_addr) == RS_NONE) |=> (rd_data == '0)); // R5
    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && decode_off(wr_addr) == RS_NONE) |=>
        ($stable(cur_x) && $stable(cur_y) && $stable(misc_q))); // R5
endmodule

// File: rtl/curs_pixel.sv
// Pixel stage of the cursor overlay. Works out whether the incoming pixel
// lies inside the visible part of the cursor and fetches that cursor row.
// Replaces the pixel according to the mask and colour-select bits, with
// bit 31 as the leftmost column. Registers the result, so latency is one
// clock. Assumes that the registers it reads are updated only at clock edges.
module curs_pixel
    import curs_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pix_valid_i,
    input  logic [COORD_W-1:0]   pix_x,
    input  logic [COORD_W-1:0]   pix_y,
    input  logic [PIX_W-1:0]     pix_data_i,
    input  logic [PIX_W-1:0]     colour_a,
    input  logic [PIX_W-1:0]     colour_b,
    input  logic [COORD_W-1:0]   active_width,
    input  logic [COORD_W-1:0]   cur_x,
    input  logic [COORD_W-1:0]   cur_y,
    output logic [IDX_W-1:0]     row_idx,
    input  logic [ROW_W-1:0]     row_mask,
    input  logic [ROW_W-1:0]     row_sel,
    output logic                 pix_valid_o,
    output logic [PIX_W-1:0]     pix_data_o
);
    logic [COORD_W:0]  y_off;
    logic [COORD_W:0]  x_off;
    logic              row_hit;
    logic              col_hit;
    logic              shown;
    logic [IDX_W-1:0]  bit_pos;
    logic [PIX_W-1:0]  next_pix;

    // Window test: offsets from the cursor corner, widened so they cannot wrap.
    always_comb begin
        y_off   = {1'b0, pix_y} - {1'b0, cur_y};
        x_off   = {1'b0, pix_x} - {1'b0, cur_x};
        row_hit = (pix_y >= cur_y) && (y_off < (COORD_W+1)'(CURS_DIM));
        col_hit = (pix_x >= cur_x) && (x_off < (COORD_W+1)'(CURS_DIM));
        shown   = (cur_x < active_width) && (pix_x < active_width);
        row_idx = y_off[IDX_W-1:0];
        bit_pos = ~x_off[IDX_W-1:0];
    end

    // Colour choice from the mask and colour-select bits of this column.
    always_comb begin
        next_pix = pix_data_i;
        if (row_hit && col_hit && shown && row_mask[bit_pos])
            next_pix = row_sel[bit_pos] ? colour_b : colour_a;
    end

    // Output register; the valid flag moves with the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid_o <= 1'b0;
            pix_data_o  <= '0;
        end else begin
            pix_valid_o <= pix_valid_i;
            pix_data_o  <= next_pix;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_i |=> pix_valid_o); // R10
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_i |=> !pix_valid_o); // R10
    AST_CLIP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_x >= active_width) |=> (pix_data_o == $past(pix_data_i))); // R9
    AST_ABOVE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_y < cur_y) |=> (pix_data_o == $past(pix_data_i))); // R6
endmodule

// File: rtl/cursor_overlay.sv
// Top of the cursor overlay. Joins the register window to the pixel stage.
// Assumes one pixel per clock at most, with coordinates in screen pixels.
module cursor_overlay
    import curs_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [OFF_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [OFF_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    input  logic [COORD_W-1:0]   active_width,
    input  logic [PIX_W-1:0]     colour_a,
    input  logic [PIX_W-1:0]     colour_b,
    input  logic                 pix_valid_i,
    input  logic [COORD_W-1:0]   pix_x,
    input  logic [COORD_W-1:0]   pix_y,
    input  logic [PIX_W-1:0]     pix_data_i,
    output logic                 pix_valid_o,
    output logic [PIX_W-1:0]     pix_data_o
);
    logic [COORD_W-1:0] cur_x;
    logic [COORD_W-1:0] cur_y;
    logic [IDX_W-1:0]   row_idx;
    logic [ROW_W-1:0]   row_mask;
    logic [ROW_W-1:0]   row_sel;

    curs_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .cur_x    (cur_x),
        .cur_y    (cur_y),
        .row_idx  (row_idx),
        .row_mask (row_mask),
        .row_sel  (row_sel)
    );

    curs_pixel #(.PIX_W(PIX_W)) u_pix (
        .clk          (clk),
        .rst_n        (rst_n),
        .pix_valid_i  (pix_valid_i),
        .pix_x        (pix_x),
        .pix_y        (pix_y),
        .pix_data_i   (pix_data_i),
        .colour_a     (colour_a),
        .colour_b     (colour_b),
        .active_width (active_width),
        .cur_x        (cur_x),
        .cur_y        (cur_y),
        .row_idx      (row_idx),
        .row_mask     (row_mask),
        .row_sel      (row_sel),
        .pix_valid_o  (pix_valid_o),
        .pix_data_o   (pix_data_o)
    );
endmodule

// File: tb/sim_cursor_overlay.sv
module sim_cursor_overlay;
    localparam int PIX_W = 24;
    localparam logic [23:0] CA = 24'h0000AA;
    localparam logic [23:0] CB = 24'h00BB00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] active_width = 16'd640;
    logic [23:0] colour_a = CA;
    logic [23:0] colour_b = CB;
    logic        pix_valid_i = 1'b0;
    logic [15:0] pix_x = '0;
    logic [15:0] pix_y = '0;
    logic [23:0] pix_data_i = '0;
    logic        pix_valid_o;
    logic [23:0] pix_data_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cursor_overlay #(.PIX_W(PIX_W)) u0 (.*);

    // Vector: {x, y, expected: 0 pass, 1 colour A, 2 colour B}
    // Cursor at (100,50); mask0=C0000001 sel0=80000000; mask5=FFFFFFFF
    // sel5=0000FFFF; mask31=00000001 sel31=00000001; width 640.
    localparam logic [33:0] VEC [12] = '{
        {16'd100, 16'd50, 2'd2},   // R7 R8 col0 bit31 B
        {16'd101, 16'd50, 2'd1},   // R7 R8 col1 bit30 A
        {16'd102, 16'd50, 2'd0},   // R8 mask 0
        {16'd131, 16'd50, 2'd1},   // R7 col31 bit0 A
        {16'd132, 16'd50, 2'd0},   // R6 right of cursor
        {16'd99,  16'd50, 2'd0},   // R6 left of cursor
        {16'd100, 16'd49, 2'd0},   // R6 above
        {16'd110, 16'd55, 2'd1},   // R8 row5 col10
        {16'd120, 16'd55, 2'd2},   // R8 row5 col20
        {16'd131, 16'd81, 2'd2},   // R6 last row last col
        {16'd131, 16'd82, 2'd0},   // R6 below
        {16'd130, 16'd81, 2'd0}    // R7 row31 col30 mask 0
    };

    function automatic logic [23:0] pick(input logic [1:0] s, input logic [23:0] p);
        return (s == 2'd0) ? p : (s == 2'd1) ? CA : CB;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        @(posedge clk); #1;
        d = rd_data;
    endtask

    task automatic pix(input logic [15:0] x, input logic [15:0] y,
                       input logic [23:0] p, output logic [23:0] o);
        @(negedge clk);
        pix_valid_i = 1'b1; pix_x = x; pix_y = y; pix_data_i = p;
        @(posedge clk); #1;
        o = pix_data_o;
        @(negedge clk);
        pix_valid_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [23:0] o;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 valid_o", {31'b0, pix_valid_o}, 32'h0);
        rd(12'h8FC, d); check("R1 position", d, 32'hF0000000);
        rd(12'h818, d); check("R1 misc", d, 32'h02000000);
        rd(12'h90C, d); check("R1 mask row3", d, 32'h0);
        pix(16'd0, 16'd0, 24'h777777, o); check("R1 parked cursor pass", {8'h0, o}, 32'h777777);

        wr(12'h8FC, {16'd100, 16'd50});
        rd(12'h8FC, d); check("R3 position readback", d, 32'h00640032);
        wr(12'h900, 32'hC0000001); wr(12'h980, 32'h80000000);
        wr(12'h914, 32'hFFFFFFFF); wr(12'h994, 32'h0000FFFF);
        wr(12'h97C, 32'h00000001); wr(12'h9FC, 32'h00000001);
        rd(12'h914, d); check("R2 mask row5", d, 32'hFFFFFFFF);
        rd(12'h997, d); check("R2 sel row5 low bits ignored", d, 32'h0000FFFF);

        foreach (VEC[i]) begin
            logic [23:0] p;
            p = 24'h100000 + 24'(i);
            pix(VEC[i][33:18], VEC[i][17:2], p, o);
            check("R6/R7/R8 vector", {8'h0, o}, {8'h0, pick(VEC[i][1:0], p)});
        end

        // R4 misc
        wr(12'h818, 32'h00000011);
        rd(12'h818, d); check("R4 misc forced bit", d, 32'h02000011);

        // R5 unmapped
        rd(12'h800, d); check("R5 unmapped read", d, 32'h0);
        wr(12'hA00, 32'hFFFFFFFF);
        wr(12'h004, 32'hFFFFFFFF);
        rd(12'h980, d); check("R5 sel row0 untouched", d, 32'h80000000);
        rd(12'h8FC, d); check("R5 position untouched", d, 32'h00640032);
        pix(16'd102, 16'd50, 24'h202020, o); check("R5 pixel unchanged", {8'h0, o}, 32'h202020);

        // R9 right clip at width 110
        active_width = 16'd110;
        pix(16'd109, 16'd55, 24'h303030, o); check("R9 inside width", {8'h0, o}, {8'h0, CA});
        pix(16'd115, 16'd55, 24'h313131, o); check("R9 clipped", {8'h0, o}, 32'h313131);

        // R6 cursor x not below width
        active_width = 16'd100;
        pix(16'd100, 16'd50, 24'h404040, o); check("R6 x equals width", {8'h0, o}, 32'h404040);
        wr(12'h8FC, {16'd99, 16'd50});
        pix(16'd99, 16'd50, 24'h414141, o); check("R6 x below width", {8'h0, o}, {8'h0, CB});
        active_width = 16'd640;
        wr(12'h8FC, {16'd100, 16'd50});

        // R10 valid and latency
        @(negedge clk);
        pix_valid_i = 1'b1; pix_x = 16'd0; pix_y = 16'd0; pix_data_i = 24'h515151;
        @(posedge clk); #1;
        check("R10 valid high", {31'b0, pix_valid_o}, 32'h1);
        check("R10 data one clock", {8'h0, pix_data_o}, 32'h515151);
        @(negedge clk) pix_valid_i = 1'b0;
        @(posedge clk); #1;
        check("R10 valid low", {31'b0, pix_valid_o}, 32'h0);

        // R11 write and pixel in the same clock
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 12'h8FC; wr_data = {16'd200, 16'd50};
        pix_valid_i = 1'b1; pix_x = 16'd100; pix_y = 16'd50; pix_data_i = 24'h606060;
        @(posedge clk); #1;
        check("R11 old position used", {8'h0, pix_data_o}, {8'h0, CB});
        @(negedge clk);
        wr_en = 1'b0; pix_data_i = 24'h616161;
        @(posedge clk); #1;
        check("R11 new position next", {8'h0, pix_data_o}, 32'h616161);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 12'h900; wr_data = 32'h0;
        pix_x = 16'd100; pix_y = 16'd50; pix_data_i = 24'h626262;
        wr_data = 32'h0;
        @(posedge clk); #1;
        @(negedge clk);
        wr_en = 1'b0; pix_valid_i = 1'b0;
        wr(12'h8FC, {16'd100, 16'd50});
        wr(12'h900, 32'hC0000001);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 12'h900; wr_data = 32'h0;
        pix_valid_i = 1'b1; pix_x = 16'd100; pix_y = 16'd50; pix_data_i = 24'h636363;
        @(posedge clk); #1;
        check("R11 old mask used", {8'h0, pix_data_o}, {8'h0, CB});
        @(negedge clk);
        wr_en = 1'b0; pix_data_i = 24'h646464;
        @(posedge clk); #1;
        check("R11 new mask next", {8'h0, pix_data_o}, 32'h646464);
        @(negedge clk) pix_valid_i = 1'b0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule